// File: doc/BRIEF.md
# View Register Bank with Serial Loading

This block keeps the camera state for a scanline ray-casting video generator: player position, facing direction and camera plane. Each is a pair of signed fixed-point values with 6 integer and 10 fraction bits. A host sends a new view over a write-only three-wire serial link (select active low, clock, data), and that link is brought into the pixel clock domain through two-flop synchronisers. A complete frame waits in a shadow copy and becomes live at the start of vertical blanking, so one picture never mixes two views.

After reset the block holds a fixed angled view. Two drift inputs move the position by a small step once per frame, without any help from the host. A debug input turns on an overlay that draws every register bit as a small square near the top-left corner of the screen.

Top module: `view_reg_bank`

## Requirements
- R1: Synchronous reset loads the preset view: pos_x=0x2200, pos_y=0x1100, dir_x=0x02D4, dir_y=0xFD2C, plane_x=0x016A, plane_y=0x016A.
- R2: A serial frame is 96 bits, sampled on the rising edge of the synchronised sclk while the synchronised select is low. The data goes MSB first in the order pos_x, pos_y, dir_x, dir_y, plane_x, plane_y, 16 bits each.
- R3: Live outputs change only on the frame-start cycle, which is the cycle where pix_y equals 480 and pix_x equals 0. A received frame stays pending until the next frame-start cycle, and the outputs show the new value on the clock edge that ends that cycle.
- R4: When select rises after any bit count other than 96, the frame is discarded and the live view is left unchanged.
- R5: While drift_x is high, each frame-start cycle adds 16 (1/64) to pos_x, with 16-bit wrap-around.
- R6: While drift_y is high, each frame-start cycle adds 16 to pos_y. Both drifts may be active together.
- R7: If a serial frame is pending at frame start, the frame is loaded and no drift step is applied for that frame.
- R8: When dbg_en is high, pixel (x,y) inside the 128x48 area at the top-left corner lights dbg_pix, one cycle later, with the bit of register y/8 at position 15-x/8. Register 0 is pos_x and register 5 is plane_y.
- R9: dbg_pix is 0 one cycle after any pixel outside that area, and one cycle after any cycle where dbg_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sclk | input | 1 | Serial clock from host (asynchronous) |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Serial select, active low |
| drift_x | input | 1 | Drift position X each frame |
| drift_y | input | 1 | Drift position Y each frame |
| dbg_en | input | 1 | Enable register overlay |
| pix_x | input | 10 | Current pixel column |
| pix_y | input | 10 | Current pixel row |
| pos_x | output | 16 | Player X position, Q6.10 |
| pos_y | output | 16 | Player Y position, Q6.10 |
| dir_x | output | 16 | Facing direction X |
| dir_y | output | 16 | Facing direction Y |
| plane_x | output | 16 | Camera plane X |
| plane_y | output | 16 | Camera plane Y |
| dbg_pix | output | 1 | Overlay pixel |

## Verification
Serial bits take two synchroniser stages plus one edge-detect register. The bench therefore holds every sclk level for four clocks and waits ten clocks after select rises before it treats a frame as received. The view outputs move on the edge that ends the frame-start cycle. The bench drives that cycle from one falling edge and reads the outputs at the next falling edge. dbg_pix has one register of latency, so each overlay coordinate is applied at a falling edge and checked one full clock later. Before every frame-start cycle the bench also reads the outputs, to show that a pending frame has not leaked through early.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  parameter int unsigned VW       = 16;
  parameter int unsigned NUM_REGS = 6;
  localparam int unsigned FRAME_BITS = VW * NUM_REGS;

  localparam int unsigned IDX_PX = 0;
  localparam int unsigned IDX_PY = 1;

  typedef logic [NUM_REGS-1:0][VW-1:0] view_t;

  // index 0 = pos_x ... index 5 = plane_y
  localparam view_t VIEW_PRESET = {16'h016A, 16'h016A, 16'hFD2C,
                                   16'h02D4, 16'h1100, 16'h2200};
endpackage

// File: rtl/vrb_spi_rx.sv
module vrb_spi_rx #(
  parameter int unsigned FRAME_BITS  = 96,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk,
  input  logic                  mosi,
  input  logic                  csn,
  output logic                  frame_ok,
  output logic [FRAME_BITS-1:0] frame_data
);
  localparam int unsigned CW = $clog2(FRAME_BITS + 2);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] sck_s, mo_s, cs_s;
  logic         sck_d, cs_d;
  logic [CW-1:0] cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic sck_rise, cs_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      mo_s  <= '0;
      cs_s  <= '1;
    end else begin
      sck_s <= {sck_s[TOP-1:0], sclk};
      mo_s  <= {mo_s[TOP-1:0], mosi};
      cs_s  <= {cs_s[TOP-1:0], csn};
    end
  end

  assign sck_rise = sck_s[TOP] & ~sck_d;
  assign cs_rise  = cs_s[TOP] & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      cnt      <= '0;
      shreg    <= '0;
      frame_ok <= 1'b0;
    end else begin
      sck_d    <= sck_s[TOP];
      cs_d     <= cs_s[TOP];
      frame_ok <= 1'b0;
      if (cs_rise) begin
        frame_ok <= (cnt == CW'(FRAME_BITS));
        cnt      <= '0;
      end else if (!cs_s[TOP] && sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], mo_s[TOP]};
        if (cnt != CW'(FRAME_BITS + 1)) cnt <= cnt + 1'b1;
      end
    end
  end

  assign frame_data = shreg;
endmodule

// File: rtl/vrb_view_store.sv
module vrb_view_store
  import vrb_pkg::*;
#(
  parameter int unsigned DRIFT_STEP = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_ok,
  input  logic [FRAME_BITS-1:0] frame_data,
  input  logic                  frame_start,
  input  logic                  drift_x,
  input  logic                  drift_y,
  output view_t                 live,
  output logic                  pending
);
  view_t incoming, shadow;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign incoming[g] = frame_data[FRAME_BITS-1-g*VW -: VW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live    <= VIEW_PRESET;
      shadow  <= '0;
      pending <= 1'b0;
    end else begin
      if (frame_ok) begin
        shadow  <= incoming;
        pending <= 1'b1;
      end
      if (frame_start) begin
        if (frame_ok) begin
          live    <= incoming;
          pending <= 1'b0;
        end else if (pending) begin
          live    <= shadow;
          pending <= 1'b0;
        end else begin
          if (drift_x) live[IDX_PX] <= live[IDX_PX] + VW'(DRIFT_STEP);
          if (drift_y) live[IDX_PY] <= live[IDX_PY] + VW'(DRIFT_STEP);
        end
      end
    end
  end
endmodule

// File: rtl/vrb_dbg_overlay.sv
module vrb_dbg_overlay
  import vrb_pkg::*;
#(
  parameter int unsigned XW      = 10,
  parameter int unsigned YW      = 10,
  parameter int unsigned SQ_LOG2 = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  view_t         view,
  output logic          dbg_pix
);
  localparam int unsigned CBW = $clog2(VW);
  localparam int unsigned RW  = $clog2(NUM_REGS);

  logic [XW-1:0] col;
  logic [YW-1:0] row;
  logic          lit;

  assign col = pix_x >> SQ_LOG2;
  assign row = pix_y >> SQ_LOG2;

  always_comb begin
    lit = 1'b0;
    if (col < XW'(VW) && row < YW'(NUM_REGS))
      lit = view[row[RW-1:0]][~col[CBW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_pix <= 1'b0;
    else     dbg_pix <= en & lit;
  end
endmodule

// File: rtl/view_reg_bank.sv
module view_reg_bank
  import vrb_pkg::*;
#(
  parameter int unsigned XW          = 10,
  parameter int unsigned YW          = 10,
  parameter int unsigned V_ACT       = 480,
  parameter int unsigned SQ_LOG2     = 3,
  parameter int unsigned DRIFT_STEP  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_mosi,
  input  logic          spi_csn,
  input  logic          drift_x,
  input  logic          drift_y,
  input  logic          dbg_en,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  output logic [VW-1:0] pos_x,
  output logic [VW-1:0] pos_y,
  output logic [VW-1:0] dir_x,
  output logic [VW-1:0] dir_y,
  output logic [VW-1:0] plane_x,
  output logic [VW-1:0] plane_y,
  output logic          dbg_pix
);
  logic                  frame_ok;
  logic [FRAME_BITS-1:0] frame_data;
  logic                  frame_start;
  logic                  pending;
  view_t                 live;

  assign frame_start = (pix_y == YW'(V_ACT)) && (pix_x == '0);

  vrb_spi_rx #(.FRAME_BITS(FRAME_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .mosi(spi_mosi), .csn(spi_csn),
    .frame_ok(frame_ok), .frame_data(frame_data));

  vrb_view_store #(.DRIFT_STEP(DRIFT_STEP)) u_store (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .frame_data(frame_data),
    .frame_start(frame_start), .drift_x(drift_x), .drift_y(drift_y),
    .live(live), .pending(pending));

  vrb_dbg_overlay #(.XW(XW), .YW(YW), .SQ_LOG2(SQ_LOG2)) u_dbg (
    .clk(clk), .rst(rst), .en(dbg_en), .pix_x(pix_x), .pix_y(pix_y),
    .view(live), .dbg_pix(dbg_pix));

  assign pos_x   = live[0];
  assign pos_y   = live[1];
  assign dir_x   = live[2];
  assign dir_y   = live[3];
  assign plane_x = live[4];
  assign plane_y = live[5];
endmodule

// File: rtl/vrb_checker.sv
module vrb_checker #(
  parameter int unsigned XW         = 10,
  parameter int unsigned YW         = 10,
  parameter int unsigned V_ACT      = 480,
  parameter int unsigned SQ_LOG2    = 3,
  parameter int unsigned DRIFT_STEP = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic          drift_x,
  input logic          dbg_en,
  input logic          dbg_pix,
  input logic [15:0]   pos_x,
  input logic [15:0]   pos_y,
  input logic          frame_ok,
  input logic          pending
);
  logic fs, outside;
  assign fs = (pix_y == YW'(V_ACT)) && (pix_x == '0);
  assign outside = (pix_x >= XW'(16 << SQ_LOG2)) || (pix_y >= YW'(6 << SQ_LOG2));

  a_r1_reset_preset: assert property (@(posedge clk)
    rst |=> (pos_x == 16'h2200 && pos_y == 16'h1100));

  a_r3_hold_between: assert property (@(posedge clk) disable iff (rst)
    !fs |=> ($stable(pos_x) && $stable(pos_y)));

  a_r4_frame_pending: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && !fs) |=> pending);

  a_r5_drift_step: assert property (@(posedge clk) disable iff (rst)
    (fs && drift_x && !pending && !frame_ok) |=> pos_x == $past(pos_x) + 16'(DRIFT_STEP));

  a_r7_spi_wins: assert property (@(posedge clk) disable iff (rst)
    (fs && pending) |=> !pending);

  a_r8_dbg_area: assert property (@(posedge clk) disable iff (rst)
    outside |=> !dbg_pix);

  a_r9_dbg_off: assert property (@(posedge clk) disable iff (rst)
    !dbg_en |=> !dbg_pix);
endmodule

bind view_reg_bank vrb_checker #(.XW(XW), .YW(YW), .V_ACT(V_ACT),
  .SQ_LOG2(SQ_LOG2), .DRIFT_STEP(DRIFT_STEP)) u_chk (
  .clk(clk), .rst(rst), .pix_x(pix_x), .pix_y(pix_y), .drift_x(drift_x),
  .dbg_en(dbg_en), .dbg_pix(dbg_pix), .pos_x(pos_x), .pos_y(pos_y),
  .frame_ok(frame_ok), .pending(pending));

// File: tb/sim_view_reg_bank.sv
module sim_view_reg_bank;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic drift_x = 1'b0, drift_y = 1'b0, dbg_en = 1'b0;
  logic [9:0] pix_x = 10'd700, pix_y = 10'd500;
  logic [15:0] pos_x, pos_y, dir_x, dir_y, plane_x, plane_y;
  logic dbg_pix;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [95:0] mdl;

  localparam logic [95:0] PRESET = 96'h2200_1100_02D4_FD2C_016A_016A;
  localparam int NV = 5;
  localparam logic [95:0] VEC_DATA [NV] = '{
    96'h1234_0567_0400_0000_0000_0200,
    96'hAAAA_5555_F0F0_0F0F_FFFF_0001,
    96'h0800_0C00_FC00_0000_0000_FE00,
    96'h7FFF_8000_0001_FFFE_1357_9BDF,
    96'h0000_FFFF_0000_FFFF_8001_7FFE };
  localparam int VEC_LEN [NV] = '{96, 95, 96, 97, 96};

  always #10 clk = ~clk;

  view_reg_bank u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_csn(csn),
    .drift_x(drift_x), .drift_y(drift_y), .dbg_en(dbg_en),
    .pix_x(pix_x), .pix_y(pix_y), .pos_x(pos_x), .pos_y(pos_y),
    .dir_x(dir_x), .dir_y(dir_y), .plane_x(plane_x), .plane_y(plane_y),
    .dbg_pix(dbg_pix));

  task automatic check(string rq, logic [95:0] act, logic [95:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [95:0] outs();
    return {pos_x, pos_y, dir_x, dir_y, plane_x, plane_y};
  endfunction

  task automatic wait_clks(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_frame(logic [95:0] data, int nbits);
    csn = 1'b0;
    wait_clks(8);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 96) ? data[95-i] : 1'b0;
      wait_clks(4);
      sclk = 1'b1;
      wait_clks(4);
      sclk = 1'b0;
    end
    wait_clks(4);
    csn = 1'b1;
    wait_clks(10);
  endtask

  task automatic frame_start();
    pix_x = 10'd0; pix_y = 10'd480;
    @(negedge clk);
    pix_x = 10'd700; pix_y = 10'd500;
  endtask

  task automatic dbg_probe(string rq, int x, int y, logic exp);
    pix_x = 10'(x); pix_y = 10'(y);
    @(negedge clk);
    check(rq, {95'b0, dbg_pix}, {95'b0, exp});
    pix_x = 10'd700; pix_y = 10'd500;
  endtask

  initial begin
    wait_clks(4);
    // R1: preset after reset
    check("R1 reset preset", outs(), PRESET);
    check("R9 dbg low in reset", {95'b0, dbg_pix}, 96'b0);
    rst = 1'b0;
    mdl = PRESET;
    wait_clks(2);

    // R2 / R4 table: valid 96-bit frames load, others are discarded
    for (int v = 0; v < NV; v++) begin
      send_frame(VEC_DATA[v], VEC_LEN[v]);
      check("R3 pending not live yet", outs(), mdl);
      frame_start();
      if (VEC_LEN[v] == 96) mdl = VEC_DATA[v];
      check(VEC_LEN[v] == 96 ? "R2 frame loaded" : "R4 bad length discarded",
            outs(), mdl);
    end

    // R3: frame start only when pix_x is 0, not at pix_x 1 on line 480
    send_frame(96'h0101_0202_0303_0404_0505_0606, 96);
    pix_x = 10'd1; pix_y = 10'd480;
    wait_clks(2);
    pix_x = 10'd700; pix_y = 10'd500;
    check("R3 no load off frame start", outs(), mdl);
    frame_start();
    mdl = 96'h0101_0202_0303_0404_0505_0606;
    check("R3 load at frame start", outs(), mdl);

    // R5: drift X
    drift_x = 1'b1;
    frame_start(); mdl[95:80] = mdl[95:80] + 16'd16;
    check("R5 drift x step", outs(), mdl);
    frame_start(); mdl[95:80] = mdl[95:80] + 16'd16;
    check("R5 drift x second step", outs(), mdl);
    // R6: both drifts
    drift_y = 1'b1;
    frame_start();
    mdl[95:80] = mdl[95:80] + 16'd16;
    mdl[79:64] = mdl[79:64] + 16'd16;
    check("R6 drift x and y", outs(), mdl);
    // R5: wrap-around
    send_frame(96'hFFF8_0000_0000_0000_0000_0000, 96);
    frame_start(); mdl = 96'hFFF8_0000_0000_0000_0000_0000;
    check("R7 spi wins over drift", outs(), mdl);
    frame_start();
    mdl[95:80] = 16'h0008; mdl[79:64] = 16'h0010;
    check("R5 R6 drift wraps", outs(), mdl);
    drift_x = 1'b0; drift_y = 1'b0;
    frame_start();
    check("R5 no drift when low", outs(), mdl);

    // R8 / R9: debug overlay
    send_frame(96'h8001_4002_0000_FFFF_00F0_A5A5, 96);
    frame_start(); mdl = 96'h8001_4002_0000_FFFF_00F0_A5A5;
    dbg_en = 1'b1;
    dbg_probe("R8 pos_x bit15", 3, 2, 1'b1);
    dbg_probe("R8 pos_x bit14", 8, 0, 1'b0);
    dbg_probe("R8 pos_x bit0", 127, 7, 1'b1);
    dbg_probe("R8 pos_y bit14", 9, 12, 1'b1);
    dbg_probe("R8 dir_x dark", 40, 20, 1'b0);
    dbg_probe("R8 dir_y lit", 64, 30, 1'b1);
    dbg_probe("R8 plane_x bit7", 67, 33, 1'b1);
    dbg_probe("R8 plane_y bit15", 0, 47, 1'b1);
    dbg_probe("R9 outside right", 128, 0, 1'b0);
    dbg_probe("R9 outside below", 0, 48, 1'b0);
    dbg_en = 1'b0;
    dbg_probe("R9 dbg_en low", 3, 2, 1'b0);

    // R1: reset again returns preset
    rst = 1'b1;
    wait_clks(2);
    rst = 1'b0;
    check("R1 reset restores preset", outs(), PRESET);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule